// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Interleaved Address Counter

This block is a single-port synchronous static memory intended to serve as the data array of a burstable cache. Every input except the output enable is captured on the rising clock edge. The captured cycle is then executed: a read lands in a registered output on the following edge, and a write is committed on that same edge. A burst is opened by either of two address strobes, one driven by the processor side and one by the cache controller side. Once a burst is open, a 2-bit counter supplies the low address bits. The counter steps only on cycles where the advance input was asserted, and it follows the interleaved order a cache processor expects: the low bits are the starting offset XOR the count.

The two strobes differ in how they treat writes. A processor-strobe cycle is always a read. A controller-strobe cycle, and any burst continuation cycle, writes when write enable is low. A strobe that arrives while the chip-select pair is not asserted closes the burst. The block then ignores continuation cycles until the next selected strobe. The shared data bus is modelled as separate input, output and output-enable ports. The output enable is gated by an asynchronous active-low enable input and is held low on write cycles and while deselected. The memory depth is set by `ADDR_W`. A depth of 32,768 words of 9 bits uses `ADDR_W = 15`. The default is kept smaller so that elaboration stays light.

The control is a three-state machine, held in the state register, that records the kind of access executed on the last edge:
- `ST_DESEL`: no burst is open and no access takes place.
- `ST_RD`: a read was executed.
- `ST_WR`: a write was executed.

Transitions, evaluated on the captured inputs:
- *open-read*: a selected processor strobe, or a selected controller strobe with write enable high. Goes from any state to `ST_RD`.
- *open-write*: a selected controller strobe with write enable low. Goes from any state to `ST_WR`.
- *close*: any strobe with the chip select not asserted. Goes from any state to `ST_DESEL`.
- *continue*: no strobe, from `ST_RD` or `ST_WR`. Goes to `ST_WR` if write enable is low, otherwise to `ST_RD`.
- *idle*: no strobe in `ST_DESEL`. Stays in `ST_DESEL`.

Top module: `burst_sram`

## Requirements
- R1: After reset, `data_oe_o` is 0, `data_o` is 0 and no burst is open, so cycles without a strobe produce no read.
- R2: Inputs present at one rising edge are captured there. The access they describe is executed on the next rising edge, where read data is loaded into `data_o`.
- R3: A strobe cycle (`adsp_n_i` = 0 or `adsc_n_i` = 0) with `cs_hi_i` = 1 and `cs_lo_n_i` = 0 opens a burst at the captured address `addr_i` and clears the burst count to 0.
- R4: On a continuation cycle (no strobe, burst open), the count increments by one when `adv_n_i` was sampled 0 and holds otherwise. With a held count, the same word is accessed again.
- R5: The accessed address keeps the upper bits of the starting address. Its low two bits are the starting low bits XOR the count, so a start offset of 1 gives 1, 0, 3, 2. The count wraps from 3 to 0, which returns to the starting word.
- R6: A cycle with `adsp_n_i` sampled 0 is a read, whatever the value of `we_n_i`.
- R7: A write of `data_i` happens when `we_n_i` is sampled 0 and `adsp_n_i` is sampled 1, on either a selected controller-strobe cycle or a continuation cycle. A later read of that word returns the written value.
- R8: A strobe cycle where the chip select is not asserted (`cs_hi_i` = 0 or `cs_lo_n_i` = 1) closes the burst. The following continuation cycles neither write nor read.
- R9: `data_oe_o` is 1 exactly while the last executed access was a read and `oe_n_i` is 0. It follows `oe_n_i` without waiting for a clock edge and is 0 after a write cycle, whatever the value of `oe_n_i`.
- R10: While no burst is open, cycles without a strobe leave the memory and the output enable untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, loaded on a strobe cycle |
| data_i | input | DATA_W | Write data |
| we_n_i | input | 1 | Active-low write enable |
| cs_hi_i | input | 1 | Active-high chip select |
| cs_lo_n_i | input | 1 | Active-low chip select |
| adsp_n_i | input | 1 | Processor-side address strobe, active low, forces a read |
| adsc_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Active-low burst advance |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| data_o | output | DATA_W | Registered read data |
| data_oe_o | output | 1 | Output-driver enable for the shared bus |

## Verification
The memory is first filled with controller-strobe write bursts. After that, every read is compared with a bench reference model. Directed bursts start from each of the four low offsets and run through the wrap, which tells the interleaved order apart from a linear one and shows where the wrap returns. Processor-strobe cycles with write enable low separate the read-forcing strobe from the write-qualifying one. Hold cycles without advance show that the count does not step on its own. Unselected strobes followed by write attempts, and idle cycles after reset, show that a closed burst touches nothing. A long stretch of random strobes, selects, advances and enables then mixes all of these transitions.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Kind of access executed on the most recent clock edge
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2
    } bs_state_t;

    // Width of the burst count (four-word groups)
    localparam int unsigned BURST_W = 2;

endpackage

// File: rtl/bsram_in_reg.sv
module bsram_in_reg #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              we_n_i,
    input  logic              cs_hi_i,
    input  logic              cs_lo_n_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              we_q,
    output logic              sel_q,
    output logic              adsp_q,
    output logic              adsc_q,
    output logic              adv_q
);

    logic cs_hi_q;
    logic cs_lo_n_q;

    // Capture stage: every synchronous input, polarity-normalised to active high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            din_q     <= '0;
            we_q      <= 1'b0;
            cs_hi_q   <= 1'b0;
            cs_lo_n_q <= 1'b1;
            adsp_q    <= 1'b0;
            adsc_q    <= 1'b0;
            adv_q     <= 1'b0;
        end else begin
            addr_q    <= addr_i;
            din_q     <= din_i;
            we_q      <= ~we_n_i;
            cs_hi_q   <= cs_hi_i;
            cs_lo_n_q <= cs_lo_n_i;
            adsp_q    <= ~adsp_n_i;
            adsc_q    <= ~adsc_n_i;
            adv_q     <= ~adv_n_i;
        end
    end

    assign sel_q = cs_hi_q & ~cs_lo_n_q;

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adsp_q,
    input  logic      adsc_q,
    input  logic      we_q,
    input  logic      sel_q,
    input  logic      adv_q,
    output bs_state_t state_q,
    output logic      load,
    output logic      step,
    output logic      do_rd,
    output logic      do_wr
);

    bs_state_t state_nx;
    logic      strobe;
    bs_state_t open_kind;

    assign strobe = adsp_q | adsc_q;

    // Kind of access opened by a selected strobe: the processor strobe forces a read
    always_comb begin
        if (adsp_q) begin
            open_kind = ST_RD;
        end else if (we_q) begin
            open_kind = ST_WR;
        end else begin
            open_kind = ST_RD;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_DESEL: begin
                if (strobe && sel_q) begin
                    state_nx = open_kind;          // open-read / open-write
                end else begin
                    state_nx = ST_DESEL;           // idle or close
                end
            end
            ST_RD, ST_WR: begin
                if (strobe) begin
                    state_nx = sel_q ? open_kind : ST_DESEL;
                end else begin
                    state_nx = we_q ? ST_WR : ST_RD; // continue
                end
            end
            default: state_nx = ST_DESEL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_nx;
        end
    end

    // Outputs to the counter and the array
    always_comb begin
        load  = strobe & sel_q;
        step  = ~strobe & adv_q & (state_q != ST_DESEL);
        do_rd = (state_nx == ST_RD);
        do_wr = (state_nx == ST_WR);
    end

    // R6
    adsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_q && sel_q) |=> (state_q == ST_RD));

    // R8
    desel_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((adsp_q || adsc_q) && !sel_q) |=> (state_q == ST_DESEL));

    // R10
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL && !adsp_q && !adsc_q) |=> (state_q == ST_DESEL));

    // R7
    access_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_rd, do_wr}));

endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter bit          INTERLEAVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int unsigned HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;
    logic [BURST_W-1:0] low_bits;

    assign cnt_nx = step ? cnt_q + 1'b1 : cnt_q;

    // Burst ordering variant
    generate
        if (INTERLEAVE) begin : g_ilv
            assign low_bits = base_q[BURST_W-1:0] ^ cnt_nx;
        end else begin : g_lin
            assign low_bits = base_q[BURST_W-1:0] + cnt_nx;
        end
    endgenerate

    always_comb begin
        if (load) begin
            eff_addr = addr_q;
        end else begin
            eff_addr = {base_q[ADDR_W-1 -: HI_W], low_bits};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_q;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_nx;
        end
    end

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> (eff_addr[ADDR_W-1 -: HI_W] == base_q[ADDR_W-1 -: HI_W]));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write committed on the edge that ends the write cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= mem[addr];
        end
    end

    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 9,
    parameter bit          INTERLEAVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              we_n_i,
    input  logic              cs_hi_i,
    input  logic              cs_lo_n_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic              we_q;
    logic              sel_q;
    logic              adsp_q;
    logic              adsc_q;
    logic              adv_q;
    bs_state_t         state_q;
    logic              load;
    logic              step;
    logic              do_rd;
    logic              do_wr;
    logic [ADDR_W-1:0] eff_addr;

    bsram_in_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_in_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .din_i     (data_i),
        .we_n_i    (we_n_i),
        .cs_hi_i   (cs_hi_i),
        .cs_lo_n_i (cs_lo_n_i),
        .adsp_n_i  (adsp_n_i),
        .adsc_n_i  (adsc_n_i),
        .adv_n_i   (adv_n_i),
        .addr_q    (addr_q),
        .din_q     (din_q),
        .we_q      (we_q),
        .sel_q     (sel_q),
        .adsp_q    (adsp_q),
        .adsc_q    (adsc_q),
        .adv_q     (adv_q)
    );

    bsram_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .adsp_q  (adsp_q),
        .adsc_q  (adsc_q),
        .we_q    (we_q),
        .sel_q   (sel_q),
        .adv_q   (adv_q),
        .state_q (state_q),
        .load    (load),
        .step    (step),
        .do_rd   (do_rd),
        .do_wr   (do_wr)
    );

    bsram_burst_ctr #(
        .ADDR_W     (ADDR_W),
        .INTERLEAVE (INTERLEAVE)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .addr_q   (addr_q),
        .eff_addr (eff_addr)
    );

    bsram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_wr),
        .rd_en   (do_rd),
        .addr    (eff_addr),
        .wdata   (din_q),
        .rdata_q (data_o)
    );

    // Asynchronous output gating
    always_comb begin
        data_oe_o = (state_q == ST_RD) && !oe_n_i;
    end

    // R9
    oe_low_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR) |-> !data_oe_o);

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !data_oe_o);

    // R8
    oe_low_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL) |-> !data_oe_o);

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] data_i = '0;
    logic              we_n_i = 1'b1;
    logic              cs_hi_i = 1'b0;
    logic              cs_lo_n_i = 1'b1;
    logic              adsp_n_i = 1'b1;
    logic              adsc_n_i = 1'b1;
    logic              adv_n_i = 1'b1;
    logic              oe_n_i = 1'b1;
    logic [DATA_W-1:0] data_o;
    logic              data_oe_o;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
        .we_n_i(we_n_i), .cs_hi_i(cs_hi_i), .cs_lo_n_i(cs_lo_n_i),
        .adsp_n_i(adsp_n_i), .adsc_n_i(adsc_n_i), .adv_n_i(adv_n_i),
        .oe_n_i(oe_n_i), .data_o(data_o), .data_oe_o(data_oe_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic [ADDR_W-1:0] m_base = '0;
    int                m_cnt = 0;
    bit                m_open = 1'b0;

    // Expectation pipeline: p1 = driven one cycle ago, p2 = two cycles ago
    bit                p1_rd = 0, p2_rd = 0;
    logic [DATA_W-1:0] p1_d = '0, p2_d = '0;
    string             p1_tag = "R1", p2_tag = "R1";
    bit                last_rd = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] b, input int c);
        logic [1:0] lo;
        lo = b[1:0] ^ 2'(c);
        return {b[ADDR_W-1:2], lo};
    endfunction

    // One bus cycle: check the access driven two cycles ago, then drive new inputs
    task automatic cyc(input bit adsp_n, input bit adsc_n, input bit adv_n, input bit we_n,
                       input logic [1:0] cs, input bit oe_n,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input string tag);
        bit                strobe, sel, rd, wr;
        logic [ADDR_W-1:0] eff;
        @(negedge clk);
        if (p2_rd) begin
            check(data_oe_o == !oe_n_i, p2_tag, "data_oe on read", data_oe_o, !oe_n_i);
            check(data_o == p2_d, p2_tag, "read data", data_o, p2_d);
        end else begin
            check(data_oe_o == 1'b0, p2_tag, "data_oe off", data_oe_o, 0);
        end
        last_rd = p2_rd;
        // reference model from the requirements
        strobe = !adsp_n || !adsc_n;
        sel    = cs[1] && !cs[0];
        rd = 0; wr = 0; eff = '0;
        if (strobe) begin
            if (sel) begin
                m_open = 1; m_base = a; m_cnt = 0; eff = a;
                if (!adsp_n) rd = 1;
                else if (!we_n) wr = 1;
                else rd = 1;
            end else begin
                m_open = 0;
            end
        end else if (m_open) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            eff = burst_addr(m_base, m_cnt);
            if (!we_n) wr = 1; else rd = 1;
        end
        p2_rd = p1_rd; p2_d = p1_d; p2_tag = p1_tag;
        p1_rd = rd; p1_tag = tag;
        p1_d  = rd ? ref_mem[eff] : '0;
        if (wr) ref_mem[eff] = d;
        adsp_n_i = adsp_n; adsc_n_i = adsc_n; adv_n_i = adv_n; we_n_i = we_n;
        cs_hi_i = cs[1]; cs_lo_n_i = cs[0]; oe_n_i = oe_n;
        addr_i = a; data_i = d;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 2'b10, 0, '0, '0, tag);
    endtask

    function automatic logic [DATA_W-1:0] rnd_d();
        return DATA_W'($urandom);
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED1);
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(data_oe_o == 1'b0, "R1", "reset data_oe", data_oe_o, 0);
        check(data_o == '0, "R1", "reset data_o", data_o, 0);
        // R1 / R10: no strobe after reset -> nothing happens even with advance
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 2'b10, 0, ADDR_W'(i), rnd_d(), "R10");

        // R7: fill the array with controller-strobe write bursts
        for (int b = 0; b < DEPTH; b += 4) begin
            cyc(1, 0, 1, 0, 2'b10, 0, ADDR_W'(b), rnd_d(), "R7");
            for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 2'b10, 0, '0, rnd_d(), "R7");
        end
        idle(2, "R7");

        // R5: processor-strobe bursts from every start offset, through the wrap
        for (int s = 0; s < 4; s++) begin
            cyc(0, 1, 1, 1, 2'b10, 0, ADDR_W'(12'h140 + s), '0, "R5");
            for (int k = 0; k < 4; k++) cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R5");
        end

        // R6: processor strobe with write enable low must read, not write
        cyc(0, 1, 1, 0, 2'b10, 0, 11'h222, 9'h1AA, "R6");
        cyc(0, 1, 1, 1, 2'b10, 0, 11'h222, '0, "R6");

        // R3: controller strobe with write enable high starts a read burst
        cyc(1, 0, 1, 1, 2'b10, 0, 11'h301, '0, "R3");
        cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R3");

        // R4: continuation without advance re-reads the same word
        cyc(1, 0, 1, 1, 2'b10, 0, 11'h0F2, '0, "R4");
        for (int k = 0; k < 3; k++) cyc(1, 1, 1, 1, 2'b10, 0, '0, '0, "R4");
        cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R4");

        // R7: write burst then read back via processor strobe
        cyc(1, 0, 1, 0, 2'b10, 0, 11'h403, 9'h011, "R7");
        cyc(1, 1, 0, 0, 2'b10, 0, '0, 9'h022, "R7");
        cyc(1, 1, 0, 0, 2'b10, 0, '0, 9'h033, "R7");
        cyc(0, 1, 1, 1, 2'b10, 0, 11'h403, '0, "R7");
        cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R7");
        cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R7");

        // R8: unselected strobes close the burst; continuation writes are dropped
        cyc(1, 0, 1, 1, 2'b10, 0, 11'h500, '0, "R8");
        cyc(1, 0, 1, 0, 2'b11, 0, 11'h500, 9'h0FF, "R8");
        cyc(1, 1, 0, 0, 2'b11, 0, '0, 9'h0EE, "R8");
        cyc(0, 1, 1, 0, 2'b00, 0, 11'h501, 9'h0DD, "R8");
        cyc(1, 1, 0, 0, 2'b10, 0, '0, 9'h0CC, "R8");
        idle(2, "R10");
        cyc(0, 1, 1, 1, 2'b10, 0, 11'h500, '0, "R8");
        cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R8");
        cyc(1, 1, 0, 1, 2'b10, 0, '0, '0, "R8");

        // R9: output enable gating, incl. change between edges
        cyc(0, 1, 1, 1, 2'b10, 1, 11'h600, '0, "R9");
        cyc(1, 1, 1, 1, 2'b10, 1, '0, '0, "R9");
        cyc(1, 1, 1, 1, 2'b10, 0, '0, '0, "R9");
        cyc(1, 1, 1, 1, 2'b10, 0, '0, '0, "R9");
        #2 oe_n_i = 1'b1;
        #1 check(data_oe_o == 1'b0, "R9", "async oe off", data_oe_o, 0);
        oe_n_i = 1'b0;
        #1 check(data_oe_o == last_rd, "R9", "async oe on", data_oe_o, last_rd);
        cyc(1, 1, 1, 0, 2'b10, 0, '0, 9'h123, "R9");
        cyc(1, 1, 1, 0, 2'b10, 0, '0, 9'h124, "R9");
        idle(2, "R9");

        // R2: random mix of all controls
        for (int i = 0; i < 4000; i++) begin
            bit pn, cn, vn, wn, on;
            logic [1:0] cs;
            pn = ($urandom % 6) != 0;
            cn = ($urandom % 5) != 0;
            vn = ($urandom % 2) != 0;
            wn = ($urandom % 2) != 0;
            on = ($urandom % 4) == 0;
            cs = (($urandom % 8) == 0) ? 2'($urandom) : 2'b10;
            cyc(pn, cn, vn, wn, cs, on, ADDR_W'($urandom), rnd_d(), "R2");
        end
        idle(3, "R2");

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule